// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides two 32-bit integers, signed or unsigned, and resolves one quotient bit on each clock. The quotient lands in the LO result register and the remainder in the HI result register. A request is one cycle of `start` while the block is idle. The block then raises `busy` until the result is written. `done` pulses high for one cycle when LO and HI hold the new result.

Before it iterates, the block looks at how many upper bits of the dividend only repeat the sign. For signed requests it tests sign extension and for unsigned requests it tests zero extension. A dividend that fits in 8, 16 or 24 bits skips 23, 15 or 7 of the 32 iterations. Signed requests are divided as magnitudes, and the signs are applied in a final write-back cycle. The surrounding logic uses `busy` to stall any later multiply or divide request until the divider is free again.

Top module: `div_early_out`

## Requirements
- R1: For an unsigned request, LO receives the quotient and HI the remainder of `dividend / divisor`.
- R2: For a signed request, the quotient truncates toward zero and the remainder has the sign of the dividend (7 / -2 gives LO = -3, HI = 1; -128 / 3 gives LO = -42, HI = -2).
- R3: A signed request of 0x80000000 divided by 0xFFFFFFFF (-1) gives LO = 0x80000000 and HI = 0.
- R4: A dividend that fits in 8 bits runs 9 iterations. `done` is high in the cycle after the 10th rising edge that follows the edge accepting `start`.
- R5: A dividend that fits in 16 bits but not in 8 runs 17 iterations, so `done` follows the 18th edge after acceptance.
- R6: A dividend that fits in 24 bits but not in 16 runs 25 iterations, so `done` follows the 26th edge after acceptance.
- R7: Any other dividend runs all 32 iterations, so `done` follows the 33rd edge after acceptance. `busy` never stays high for more than 33 cycles.
- R8: The size test uses sign extension for signed requests and zero extension for unsigned ones. For example, -128 signed fits in 8 bits, 0x80 unsigned fits in 8 bits, and 0xFFFFFF80 unsigned needs the full width.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. A `start` seen while busy is ignored: it does not change the result in progress and does not trigger a later run.
- R10: A zero divisor does not hang. The request completes with the latency of its dividend's size class and leaves some value in HI and LO.
- R11: `done` is a single-cycle pulse, and HI and LO change only in the cycle where `done` is high.
- R12: After reset, `busy` and `done` are low and HI and LO are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a divide; accepted only when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| busy | output | 1 | A divide is in progress; later requests must wait |
| done | output | 1 | One-cycle pulse: HI/LO hold the new result |
| hi | output | 32 | Remainder |
| lo | output | 32 | Quotient |

## Verification
The bench targets each size-class boundary from both sides and checks the exact completion cycle. A wrong sign or zero-extension test would finish too early, which gives a truncated quotient, or too late, which gives a wrong cycle count. Negative operands in every sign combination, and the most negative dividend divided by -1, catch sign-correction mistakes such as a remainder that follows the divisor's sign or an overflow that traps. A second `start` sent mid-run and a zero divisor are also checked. A design that restarted on the second request would corrupt the result or emit an extra `done`. A design that mishandled the zero divisor would never finish.

// File: rtl/div_pkg.sv
// Shared types for the iterative divider.
// Assumes nothing beyond a single clock domain.
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_size_class.sv
// Picks the number of iterations from the dividend's significant width.
// Assumes WIDTH is a multiple of 8. A class of k bytes needs 8k+1 steps,
// so that a negated signed value (e.g. |-128| = 128) still fits.
module div_size_class #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH + 1),
    localparam int NCLS = WIDTH / 8
) (
    input  logic [WIDTH-1:0] operand,
    input  logic             is_signed,
    output logic [CW-1:0]    iters
);
    logic [NCLS-1:1] fits;

    // One fit test per byte class: sign extension or zero extension above it.
    for (genvar k = 1; k < NCLS; k++) begin : g_cls
        assign fits[k] = is_signed
            ? ((&operand[WIDTH-1:8*k-1]) | ~(|operand[WIDTH-1:8*k-1]))
            : ~(|operand[WIDTH-1:8*k]);
    end

    // The smallest class that fits sets the iteration count.
    always_comb begin
        iters = CW'(WIDTH);
        for (int k = NCLS - 1; k >= 1; k--) begin
            if (fits[k]) iters = CW'(8 * k + 1);
        end
    end
endmodule

// File: rtl/div_step.sv
// One restoring-division step: shift in the next dividend bit, then
// subtract the divisor if it fits, recording the quotient bit.
// Assumes the incoming remainder is smaller than a nonzero divisor.
module div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic [WIDTH-1:0] quo_in,
    input  logic [WIDTH-1:0] dsr,
    output logic [WIDTH-1:0] rem_out,
    output logic [WIDTH-1:0] quo_out
);
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] diff;
    logic           fits;

    // Trial subtraction on a widened partial remainder.
    always_comb begin
        shifted = {rem_in, quo_in[WIDTH-1]};
        diff    = shifted - {1'b0, dsr};
        fits    = shifted >= {1'b0, dsr};
        rem_out = fits ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
        quo_out = {quo_in[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/div_early_out.sv
// Iterative divider with early exit on short dividends.
// One quotient bit per clock; quotient to LO, remainder to HI.
// Assumes the requester holds off while busy; starts seen when busy are dropped.
module div_early_out #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    import div_pkg::*;

    div_state_e       state_q;
    logic [WIDTH-1:0] rem_q, quo_q, dsr_q, hi_q, lo_q;
    logic [WIDTH-1:0] rem_nx, quo_nx, abs_a, abs_b;
    logic [CW-1:0]    cnt_q, iters;
    logic             negq_q, negr_q, done_q;

    // Magnitudes of the operands for signed requests.
    always_comb begin
        abs_a = (is_signed && dividend[WIDTH-1]) ? -dividend : dividend;
        abs_b = (is_signed && divisor[WIDTH-1])  ? -divisor  : divisor;
    end

    div_size_class #(.WIDTH(WIDTH)) u_class (
        .operand   (dividend),
        .is_signed (is_signed),
        .iters     (iters)
    );

    div_step #(.WIDTH(WIDTH)) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .dsr     (dsr_q),
        .rem_out (rem_nx),
        .quo_out (quo_nx)
    );

    // Sequencer: accept, iterate, apply signs and write HI/LO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            quo_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
            done_q  <= 1'b0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        rem_q   <= '0;
                        quo_q   <= abs_a << (WIDTH - int'(iters));
                        dsr_q   <= abs_b;
                        cnt_q   <= iters;
                        negq_q  <= is_signed & (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
                        negr_q  <= is_signed & dividend[WIDTH-1];
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= quo_nx;
                    cnt_q <= cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    lo_q    <= negq_q ? -quo_q : quo_q;
                    hi_q    <= negr_q ? -rem_q : rem_q;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
    assign hi   = hi_q;
    assign lo   = lo_q;
endmodule

// File: rtl/div_early_out_chk.sv
// Protocol checker for the divider, bound to every instance.
// Assumes synchronous active-low reset on rst_n.
module div_early_out_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] lo
);
    logic [7:0] busy_cnt;

    // Counts consecutive busy cycles for the latency bound.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 8'd1;
        else           busy_cnt <= '0;
    end

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi != $past(hi)) || (lo != $past(lo))) |-> done);

    assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 8'(WIDTH + 1));
endmodule

bind div_early_out div_early_out_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .hi    (hi),
    .lo    (lo)
);

// File: tb/div_early_out_test.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module div_early_out_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int extra_done = 0;
    bit finished = 0;

    logic [31:0] q_hi[$];
    logic [31:0] q_lo[$];
    int          q_lat[$];
    int          q_t0[$];
    bit          q_val[$];
    string       q_tag[$];
    string       q_ltag[$];

    div_early_out uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected iteration count from the numeric range of the dividend.
    function automatic int exp_iters(input bit sg, input logic [31:0] a);
        longint v;
        v = sg ? longint'($signed(a)) : longint'(a);
        if (sg) begin
            if (v >= -128 && v <= 127) return 9;
            if (v >= -32768 && v <= 32767) return 17;
            if (v >= -8388608 && v <= 8388607) return 25;
        end else begin
            if (v < 256) return 9;
            if (v < 65536) return 17;
            if (v < 16777216) return 25;
        end
        return 32;
    endfunction

    function automatic string lat_tag(input int n);
        case (n)
            9:  return "R4";
            17: return "R5";
            25: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Driver: issue one request and queue what it must produce.
    task automatic run(input bit sg, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
        logic [31:0] eq, er;
        int n;
        while (busy) @(negedge clk);
        if (b == 0) begin
            eq = '0; er = '0;
        end else if (sg && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            eq = 32'h8000_0000; er = '0;
        end else if (sg) begin
            eq = 32'($signed(a) / $signed(b));
            er = 32'($signed(a) % $signed(b));
        end else begin
            eq = a / b; er = a % b;
        end
        n = exp_iters(sg, a);
        q_hi.push_back(er); q_lo.push_back(eq);
        q_lat.push_back(n + 1); q_t0.push_back(cyc + 1);
        q_val.push_back(b != 0); q_tag.push_back(tag);
        q_ltag.push_back(b == 0 ? "R10" : lat_tag(n));
        is_signed = sg; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pop and compare on every done pulse.
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (prev_done) check(1'b0, "R11", 32'(done), 32'h0);
            if (q_lo.size() == 0) begin
                extra_done++;
                check(1'b0, "R9", 32'(done), 32'h0);
            end else begin
                logic [31:0] eh, el;
                int lat, t0;
                bit v;
                string tg, lt;
                eh = q_hi.pop_front(); el = q_lo.pop_front();
                lat = q_lat.pop_front(); t0 = q_t0.pop_front();
                v = q_val.pop_front(); tg = q_tag.pop_front(); lt = q_ltag.pop_front();
                if (v) begin
                    check(lo == el, {tg, " LO"}, lo, el);
                    check(hi == eh, {tg, " HI"}, hi, eh);
                end
                check((cyc - t0) == lat, {lt, " latency"}, 32'(cyc - t0), 32'(lat));
            end
        end
        prev_done <= done;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(busy == 1'b0, "R12 busy", 32'(busy), 32'h0);
        check(done == 1'b0, "R12 done", 32'(done), 32'h0);
        check(hi == 32'h0 && lo == 32'h0, "R12 hilo", hi | lo, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run(1'b0, 32'd100, 32'd7, "R1");
        run(1'b0, 32'h0000_0080, 32'd3, "R8");
        run(1'b0, 32'h0000_1234, 32'd10, "R1");
        run(1'b0, 32'h0001_2345, 32'h10, "R1");
        run(1'b0, 32'hFFFF_FF80, 32'd5, "R8");
        run(1'b0, 32'hDEAD_BEEF, 32'h0001_0001, "R1");
        run(1'b1, 32'hFFFF_FF80, 32'd3, "R8");
        run(1'b1, 32'd7, 32'hFFFF_FFFE, "R2");
        run(1'b1, 32'hFFFF_FF7F, 32'd4, "R2");
        run(1'b1, -32'sd100000, 32'd7, "R2");
        run(1'b1, 32'h8765_4321, 32'hFFFF_FF00, "R2");
        run(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
        run(1'b0, 32'd50, 32'd0, "R10");
        run(1'b1, 32'h7FFF_FFFF, 32'd0, "R10");

        // R9: a second start during a run is ignored
        run(1'b0, 32'd1000, 32'd10, "R9");
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R9 busy", 32'(busy), 32'h1);
        is_signed = 1'b0; dividend = 32'd7; divisor = 32'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R9 no relaunch", 32'(busy), 32'h0);
        check(extra_done == 0, "R9 extra done", 32'(extra_done), 32'h0);
        // R11: results hold while idle
        check(lo == 32'd100 && hi == 32'd0, "R11 hold", lo, 32'd100);

        while (q_lo.size() != 0) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule